// File: doc/BRIEF.md
# Link Stop and Re-initialisation Sequencer

This block drives the transmit control line and the transmitter output enable of a point-to-point link while a stop request takes the link down and while the link comes back up afterwards. While the stop request is held, the link sits disconnected. Depending on a three-state configuration bit, the transmitter is either released to high impedance, with the receivers told to expect an undriven input and the link clock halted, or it keeps driving with the clock still running.

When the stop request is released, the sequencer first emits a one-cycle pulse. This pulse tells the register block to apply any link widths that were written while the link was up. The sequencer then raises the transmit control line and waits for the receive control line to be sampled high. Only then does the hold interval start. The interval is 16 bit-time ticks when the extended-control bit is 0, and 50 microsecond ticks when it is 1. It ends on the last counted tick, and the transmit control line drops in the following cycle. A new stop request in any state returns the sequencer to the disconnected state.

States: IDLE (after reset), DISCONNECTED, WAIT_RXCTL, HOLD_CTL and ACTIVE. Transitions: IDLE, WAIT_RXCTL, HOLD_CTL or ACTIVE go to DISCONNECTED on a stop request. DISCONNECTED goes to WAIT_RXCTL when the request is released. WAIT_RXCTL goes to HOLD_CTL when the receive control line is high. HOLD_CTL goes to ACTIVE on the final tick of the selected interval.

Top module: `link_stop_seq`

## Requirements
- R1: After reset the outputs are tx_ctl=0, tx_oe=1, rx_hiz_prep=0, clk_run=1 and width_apply=0, and the sequencer is in IDLE.
- R2: A stop_req sampled high at a clock edge, in any state, puts the sequencer in DISCONNECTED after that edge. There tx_ctl=0, and it stays there while stop_req is held.
- R3: In DISCONNECTED with tristate_cfg=1, the outputs are tx_oe=0, rx_hiz_prep=1 and clk_run=0.
- R4: With tristate_cfg=0, tx_oe=1, clk_run=1 and rx_hiz_prep=0 hold in every state. Outside DISCONNECTED the same three values hold for either setting.
- R5: A stop_req sampled low in DISCONNECTED moves the sequencer to WAIT_RXCTL at that edge. From that edge on, tx_ctl=1.
- R6: In WAIT_RXCTL, tx_ctl stays 1 for as long as rx_ctl stays low, and both tick inputs have no effect.
- R7: The hold interval begins at the edge that samples rx_ctl high in WAIT_RXCTL, and ticks in that cycle are not counted. With a sampled ext_ctl_cfg of 0, tx_ctl stays 1 until the edge that counts the 16th bit_tick, then reads 0 (ACTIVE). us_tick is ignored.
- R8: With a sampled ext_ctl_cfg of 1, the hold ends on the 50th us_tick in the same way, and bit_tick is ignored.
- R9: ext_ctl_cfg is sampled at the edge that starts the hold interval. Changes to it during HOLD_CTL do not change the interval's length.
- R10: A stop request during WAIT_RXCTL or HOLD_CTL aborts the sequence. The next hold interval counts from zero.
- R11: width_apply is high for exactly the one cycle after each DISCONNECTED to WAIT_RXCTL transition, and is 0 at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | Request to disconnect the link |
| rx_ctl | input | 1 | Sampled receive control line |
| ext_ctl_cfg | input | 1 | 1 selects the long (microsecond) hold, 0 the short (bit-time) hold |
| tristate_cfg | input | 1 | 1 releases the transmitter to high impedance while disconnected |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| tx_ctl | output | 1 | Transmit control line level |
| tx_oe | output | 1 | Transmitter output enable |
| rx_hiz_prep | output | 1 | Receivers should expect a high-impedance input |
| clk_run | output | 1 | Link clock is allowed to toggle |
| width_apply | output | 1 | One-cycle pulse: apply pending link widths |

## Verification
On every cycle, the assertions check these properties:
- width_apply is a single-cycle pulse that only follows a released stop request.
- A stop request always forces tx_ctl low.
- The transmitter is released and the clock halted only when tristate_cfg is set.
- The hold counter stays below its limit and never advances without a tick.

Only the bench scenarios show the exact interval lengths: 16 or 50 counted ticks, tick inputs of the wrong kind ignored, the sampling of ext_ctl_cfg at the start of the hold, and the restart from zero after an abort. These lengths are checked against tick counts kept in the bench, across both configuration bits and two tick spacings.

// File: rtl/link_stop_pkg.sv
package link_stop_pkg;

    typedef enum logic [2:0] {
        LSS_IDLE    = 3'd0,
        LSS_DISC    = 3'd1,
        LSS_WAIT_RX = 3'd2,
        LSS_HOLD    = 3'd3,
        LSS_ACTIVE  = 3'd4
    } lss_state_e;

endpackage

// File: rtl/link_stop_timer.sv
module link_stop_timer #(
    parameter int SHORT_TICKS = 16,
    parameter int LONG_TICKS  = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic long_sel,
    input  logic bit_tick,
    input  logic us_tick,
    output logic done
);
    localparam int MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int CW        = $clog2(MAX_TICKS + 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          tick_sel;
    logic [CW-1:0] last_val;

    always_comb begin
        tick_sel = long_sel ? us_tick : bit_tick;
        last_val = long_sel ? LONG_LAST : SHORT_LAST;
        done     = run && tick_sel && (cnt_q == last_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || done) begin
            cnt_q <= '0;
        end else if (tick_sel) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= last_val)); // R7
    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/link_stop_outdec.sv
module link_stop_outdec
    import link_stop_pkg::*;
(
    input  lss_state_e state,
    input  logic       tristate_cfg,
    output logic       tx_ctl,
    output logic       tx_oe,
    output logic       rx_hiz_prep,
    output logic       clk_run
);
    always_comb begin
        tx_ctl      = 1'b0;
        tx_oe       = 1'b1;
        rx_hiz_prep = 1'b0;
        clk_run     = 1'b1;
        unique case (state)
            LSS_IDLE, LSS_ACTIVE: begin
                tx_ctl = 1'b0;
            end
            LSS_DISC: begin
                tx_ctl      = 1'b0;
                tx_oe       = !tristate_cfg;
                rx_hiz_prep = tristate_cfg;
                clk_run     = !tristate_cfg;
            end
            LSS_WAIT_RX, LSS_HOLD: begin
                tx_ctl = 1'b1;
            end
            default: begin
                tx_ctl = 1'b0;
            end
        endcase
    end

    always_comb begin
        AST_HIZ_NEEDS_CFG: assert (!rx_hiz_prep || tristate_cfg); // R3
        AST_DRIVE_WHEN_CTL: assert (!tx_ctl || (tx_oe && clk_run)); // R4
    end

endmodule

// File: rtl/link_stop_seq.sv
module link_stop_seq
    import link_stop_pkg::*;
#(
    parameter int SHORT_TICKS = 16,
    parameter int LONG_TICKS  = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic rx_ctl,
    input  logic ext_ctl_cfg,
    input  logic tristate_cfg,
    input  logic bit_tick,
    input  logic us_tick,
    output logic tx_ctl,
    output logic tx_oe,
    output logic rx_hiz_prep,
    output logic clk_run,
    output logic width_apply
);
    lss_state_e state_q, state_d;
    logic       long_sel_q;
    logic       apply_q;
    logic       hold_done;
    logic       hold_start;

    assign hold_start = (state_q == LSS_WAIT_RX) && !stop_req && rx_ctl;

    link_stop_timer #(
        .SHORT_TICKS (SHORT_TICKS),
        .LONG_TICKS  (LONG_TICKS)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q == LSS_HOLD),
        .long_sel (long_sel_q),
        .bit_tick (bit_tick),
        .us_tick  (us_tick),
        .done     (hold_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LSS_IDLE: begin
                if (stop_req) state_d = LSS_DISC;
            end
            LSS_DISC: begin
                if (!stop_req) state_d = LSS_WAIT_RX;
            end
            LSS_WAIT_RX: begin
                if (stop_req)    state_d = LSS_DISC;
                else if (rx_ctl) state_d = LSS_HOLD;
            end
            LSS_HOLD: begin
                if (stop_req)       state_d = LSS_DISC;
                else if (hold_done) state_d = LSS_ACTIVE;
            end
            LSS_ACTIVE: begin
                if (stop_req) state_d = LSS_DISC;
            end
            default: state_d = LSS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= LSS_IDLE;
            long_sel_q <= 1'b0;
            apply_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            apply_q <= (state_q == LSS_DISC) && !stop_req;
            if (hold_start) long_sel_q <= ext_ctl_cfg;
        end
    end

    link_stop_outdec outdec_i (
        .state        (state_q),
        .tristate_cfg (tristate_cfg),
        .tx_ctl       (tx_ctl),
        .tx_oe        (tx_oe),
        .rx_hiz_prep  (rx_hiz_prep),
        .clk_run      (clk_run)
    );

    assign width_apply = apply_q;

    AST_STOP_DROPS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (!tx_ctl && !width_apply)); // R2
    AST_APPLY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        width_apply |=> !width_apply); // R11
    AST_APPLY_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        width_apply |-> (!$past(stop_req) && tx_ctl)); // R5
    AST_OE_OFF_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> (tristate_cfg && !tx_ctl && !clk_run)); // R3
    AST_DRIVEN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !tristate_cfg |-> (tx_oe && clk_run && !rx_hiz_prep)); // R4
    AST_HOLD_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LSS_HOLD && !stop_req && !bit_tick && !us_tick) |=> (state_q == LSS_HOLD)); // R7
    AST_WAIT_NEEDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LSS_WAIT_RX && !stop_req && !rx_ctl) |=> tx_ctl); // R6

endmodule

// File: tb/link_stop_seq_tb.sv
module link_stop_seq_tb_top;
    localparam int SHORT_N = 16;
    localparam int LONG_N  = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 1'b0, rx_ctl = 1'b0, ext_ctl_cfg = 1'b0, tristate_cfg = 1'b0;
    logic bit_tick = 1'b0, us_tick = 1'b0;
    logic tx_ctl, tx_oe, rx_hiz_prep, clk_run, width_apply;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    link_stop_seq #(.SHORT_TICKS(SHORT_N), .LONG_TICKS(LONG_N)) dut_i (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .rx_ctl(rx_ctl),
        .ext_ctl_cfg(ext_ctl_cfg), .tristate_cfg(tristate_cfg),
        .bit_tick(bit_tick), .us_tick(us_tick), .tx_ctl(tx_ctl), .tx_oe(tx_oe),
        .rx_hiz_prep(rx_hiz_prep), .clk_run(clk_run), .width_apply(width_apply)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {tx_ctl, tx_oe, rx_hiz_prep, clk_run, width_apply};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {ctl,oe,hiz,clk,apply} actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_disc(input logic tri_on);
        return {1'b0, !tri_on, tri_on, !tri_on, 1'b0};
    endfunction

    task automatic do_stop(input string req);
        stop_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk(req, exp_disc(tristate_cfg));
        end
    endtask

    task automatic do_release();
        stop_req = 1'b0;
        step();
        chk("R5 R11 release", 5'b11011);
        step();
        chk("R11 pulse ends", 5'b11010);
    endtask

    task automatic wait_rx(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            bit_tick = 1'b1;
            us_tick  = (i % 2) == 0;
            step();
            chk("R6 wait ignores ticks", 5'b11010);
        end
        bit_tick = 1'b0;
        us_tick  = 1'b0;
        rx_ctl   = 1'b1;
        bit_tick = 1'b1;
        us_tick  = 1'b1;
        step();
        chk("R7 hold start", 5'b11010);
        rx_ctl   = 1'b0;
    endtask

    task automatic run_hold(input logic ext, input int gap, input int abort_at);
        int need;
        int n;
        int cyc;
        logic sel;
        need = ext ? LONG_N : SHORT_N;
        n = 0;
        cyc = 0;
        while (n < need) begin
            sel = (cyc % gap) == (gap - 1);
            bit_tick = ext ? !sel : sel;
            us_tick  = ext ? sel : !sel;
            if (cyc == 2) ext_ctl_cfg = !ext;
            step();
            if (sel) n++;
            if (n < need) chk(ext ? "R8 R9 long hold" : "R7 R9 short hold", 5'b11010);
            else          chk(ext ? "R8 long hold ends" : "R7 short hold ends", 5'b01010);
            cyc++;
            if (abort_at != 0 && n == abort_at) break;
        end
        bit_tick = 1'b0;
        us_tick  = 1'b0;
        ext_ctl_cfg = ext;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1;
        step();
        rst_n = 1'b1;
        chk("R1 reset", 5'b01010);
        step();
        chk("R1 idle holds", 5'b01010);
        for (int t = 0; t < 2; t++) begin
            for (int e = 0; e < 2; e++) begin
                for (int g = 1; g <= 3; g += 2) begin
                    tristate_cfg = t[0];
                    ext_ctl_cfg  = e[0];
                    do_stop(t[0] ? "R2 R3 disconnect" : "R2 R4 disconnect");
                    do_release();
                    do_stop("R10 stop in wait");
                    do_release();
                    wait_rx(4);
                    run_hold(e[0], g, 5);
                    do_stop("R10 stop in hold");
                    do_release();
                    wait_rx(2);
                    run_hold(e[0], g, 0);
                    for (int i = 0; i < 3; i++) begin
                        bit_tick = 1'b1;
                        us_tick  = 1'b1;
                        step();
                        chk("R4 R11 active", 5'b01010);
                    end
                    bit_tick = 1'b0;
                    us_tick  = 1'b0;
                end
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule